// File: doc/BRIEF.md
# Processor Clock Idle Gate

This block switches the processor clock on and off to give the core an idle mode, while the free-running master clock that feeds it keeps toggling. Other bus masters on that master clock therefore go on moving data while the processor sleeps. Software turns the processor clock off through a write-one-to-disable register. Software turns it back on through a write-one-to-enable register. A read-only status vector reports whether the clock is live.

A disable request does not stop the clock at once. The request waits until the core reports that the instruction in progress has completed, or that the core sits in its wait-for-interrupt state. The clock is then removed. Pairing a disable with a wait-for-interrupt is how the core enters idle. Any fast or normal interrupt whose enable mask bit is set brings the clock back, and it also cancels a stop that is still waiting. The gated clock is formed by a low-phase-transparent latch followed by an AND gate, so it never emits a shortened pulse.

Top module: `pcg_idle_ctrl`

## Requirements
- R1: When reset is applied and after it is released, the processor clock runs and status bit 0 reads 1.
- R2: A write of 1 to bit 0 of the disable port keeps the clock running (status bit 0 = 1) until insn_done is seen high. The clock stops (status bit 0 = 0) at the clock edge that samples insn_done.
- R3: While a stop is pending, wfi_req high also counts as the instruction having finished, and the clock stops at that edge.
- R4: Status bit 0 is the live clock state. Status bits above bit 0 always read 0.
- R5: While the clock is stopped, fiq high with fiq_en high restarts it at the next edge.
- R6: irq high with irq_en high restarts a stopped clock. The same condition during a pending stop cancels that stop, so a later insn_done leaves the clock running.
- R7: An interrupt line whose enable bit is low has no effect, whether the clock is stopped or a stop is pending.
- R8: A write of 1 to bit 0 of the enable port restarts a stopped clock at the next edge.
- R9: If the enable and disable ports both write 1 to bit 0 in the same cycle, the disable takes effect.
- R10: Writes that do not set bit 0 (for example data 0x02) on either port leave the clock state unchanged.
- R11: The gated clock pclk pulses on every master clock cycle while the clock is on, stays low while it is off, and its gate enable changes only while clk is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| set_we | input | 1 | Write strobe for the enable (write-one-to-set) register |
| set_data | input | DW | Enable register write data; bit 0 selects the processor clock |
| clr_we | input | 1 | Write strobe for the disable (write-one-to-clear) register |
| clr_data | input | DW | Disable register write data; bit 0 selects the processor clock |
| wfi_req | input | 1 | Core is in its wait-for-interrupt state |
| insn_done | input | 1 | Core has finished the instruction in progress |
| fiq | input | 1 | Fast interrupt request line |
| irq | input | 1 | Normal interrupt request line |
| fiq_en | input | 1 | Enable mask for fiq |
| irq_en | input | 1 | Enable mask for irq |
| pclk | output | 1 | Gated processor clock |
| status | output | DW | Status register; bit 0 = processor clock on |

## Verification
The gate is driven through its full cycle several times, each with a different trigger. A stop completes by insn_done on one pass and by wfi_req on another. A wake comes from fiq, from irq, or from a software enable. This shows that each path works on its own. Masked interrupts are applied both while idle and while a stop is pending, to separate mask handling from wake handling. Simultaneous enable and disable writes, and writes to other bits, separate priority from address decode. Pulses on pclk are counted over windows in the on and off states.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_IDLE  = 2'd2
  } pcg_state_e;

  localparam int unsigned PCLK_BIT = 0;
endpackage

// File: rtl/pcg_regs.sv
module pcg_regs #(
  parameter int unsigned DW = 8
) (
  input  logic          set_we,
  input  logic [DW-1:0] set_data,
  input  logic          clr_we,
  input  logic [DW-1:0] clr_data,
  input  logic          clk_on,
  output logic          set_hit,
  output logic          clr_hit,
  output logic [DW-1:0] status
);
  import pcg_pkg::*;

  always_comb begin
    set_hit = set_we & set_data[PCLK_BIT];
    clr_hit = clr_we & clr_data[PCLK_BIT];
  end

  generate
    for (genvar b = 0; b < DW; b++) begin : g_sts
      if (b == PCLK_BIT) begin : g_live
        assign status[b] = clk_on;
      end else begin : g_zero
        assign status[b] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/pcg_wake.sv
module pcg_wake #(
  parameter int unsigned NSRC = 2
) (
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] mask_en,
  output logic            wake
);
  logic [NSRC-1:0] live;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign live[i] = req[i] & mask_en[i];
    end
  endgenerate

  assign wake = |live;
endmodule

// File: rtl/pcg_fsm.sv
module pcg_fsm (
  input  logic clk,
  input  logic rst_ni,
  input  logic set_hit,
  input  logic clr_hit,
  input  logic wake,
  input  logic insn_done,
  input  logic wfi_req,
  output logic clk_on
);
  import pcg_pkg::*;

  pcg_state_e state_q, state_d;
  logic       restart;
  logic       finished;

  always_comb begin
    restart  = wake | (set_hit & ~clr_hit);
    finished = insn_done | wfi_req;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (clr_hit) state_d = ST_DRAIN;
      ST_DRAIN: begin
        if (restart)       state_d = ST_RUN;
        else if (finished) state_d = ST_IDLE;
      end
      ST_IDLE:  if (restart) state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  assign clk_on = (state_q != ST_IDLE);

  p_dis_wins_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_RUN && clr_hit) |=> (state_q == ST_DRAIN));

  p_wait_done_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_DRAIN && !insn_done && !wfi_req && !wake && !set_hit) |=> clk_on);

  p_stop_on_done_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_DRAIN && (insn_done || wfi_req) && !wake && !set_hit) |=> !clk_on);

  p_wake_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q != ST_RUN && wake) |=> (state_q == ST_RUN));

  p_masked_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_IDLE && !wake && !set_hit) |=> !clk_on);
endmodule

// File: rtl/pcg_clkgate.sv
module pcg_clkgate (
  input  logic clk,
  input  logic rst_ni,
  input  logic en,
  output logic gclk
);
  logic en_lat;

  always_latch begin
    if (!clk) en_lat = en;
  end

  assign gclk = clk & en_lat;

  always @(en_lat) begin
    if (rst_ni) begin
      p_no_runt_r11: assert (!clk);
    end
  end
endmodule

// File: rtl/pcg_idle_ctrl.sv
module pcg_idle_ctrl #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_we,
  input  logic [DW-1:0] set_data,
  input  logic          clr_we,
  input  logic [DW-1:0] clr_data,
  input  logic          wfi_req,
  input  logic          insn_done,
  input  logic          fiq,
  input  logic          irq,
  input  logic          fiq_en,
  input  logic          irq_en,
  output logic          pclk,
  output logic [DW-1:0] status
);
  localparam int unsigned NSRC = 2;

  logic [1:0] rst_sync_q;
  logic       rst_ni;
  logic       set_hit, clr_hit, wake, clk_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  pcg_regs #(.DW(DW)) u_regs (
    .set_we   (set_we),
    .set_data (set_data),
    .clr_we   (clr_we),
    .clr_data (clr_data),
    .clk_on   (clk_on),
    .set_hit  (set_hit),
    .clr_hit  (clr_hit),
    .status   (status)
  );

  pcg_wake #(.NSRC(NSRC)) u_wake (
    .req     ({fiq, irq}),
    .mask_en ({fiq_en, irq_en}),
    .wake    (wake)
  );

  pcg_fsm u_fsm (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .set_hit   (set_hit),
    .clr_hit   (clr_hit),
    .wake      (wake),
    .insn_done (insn_done),
    .wfi_req   (wfi_req),
    .clk_on    (clk_on)
  );

  pcg_clkgate u_gate (
    .clk    (clk),
    .rst_ni (rst_ni),
    .en     (clk_on),
    .gclk   (pclk)
  );

  p_sts_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (status[DW-1:1] == '0));
endmodule

// File: tb/tb_pcg_idle_ctrl.sv
`timescale 1ns/1ps
module tb_pcg_idle_ctrl;
  localparam int DW = 8;
  localparam int NV = 22;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          set_we, clr_we, wfi_req, insn_done, fiq, irq, fiq_en, irq_en;
  logic [DW-1:0] set_data, clr_data;
  logic          pclk;
  logic [DW-1:0] status;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;

  always #5 clk = ~clk;
  always @(posedge pclk) pulses++;

  pcg_idle_ctrl #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .set_we(set_we), .set_data(set_data),
    .clr_we(clr_we), .clr_data(clr_data),
    .wfi_req(wfi_req), .insn_done(insn_done),
    .fiq(fiq), .irq(irq), .fiq_en(fiq_en), .irq_en(irq_en),
    .pclk(pclk), .status(status)
  );

  // {req, set_we, set_d, clr_we, clr_d, wfi, done, fiq, irq, fiq_en, irq_en, exp_on}
  localparam logic [24:0] VEC [NV] = '{
    {8'd1,  1'b0, 4'h0, 1'b0, 4'h0, 6'b000000, 1'b1}, // R1 idle running
    {8'd2,  1'b0, 4'h0, 1'b1, 4'h1, 6'b000000, 1'b1}, // R2 disable pending
    {8'd2,  1'b0, 4'h0, 1'b0, 4'h0, 6'b000000, 1'b1}, // R2 still waiting
    {8'd2,  1'b0, 4'h0, 1'b0, 4'h0, 6'b010000, 1'b0}, // R2 done -> stop
    {8'd7,  1'b0, 4'h0, 1'b0, 4'h0, 6'b000100, 1'b0}, // R7 masked irq
    {8'd7,  1'b0, 4'h0, 1'b0, 4'h0, 6'b001000, 1'b0}, // R7 masked fiq
    {8'd6,  1'b0, 4'h0, 1'b0, 4'h0, 6'b000101, 1'b1}, // R6 irq wakes
    {8'd2,  1'b0, 4'h0, 1'b1, 4'h1, 6'b000000, 1'b1}, // R2 disable
    {8'd3,  1'b0, 4'h0, 1'b0, 4'h0, 6'b100000, 1'b0}, // R3 wfi stops
    {8'd5,  1'b0, 4'h0, 1'b0, 4'h0, 6'b001010, 1'b1}, // R5 fiq wakes
    {8'd2,  1'b0, 4'h0, 1'b1, 4'h1, 6'b000000, 1'b1}, // R2 disable
    {8'd7,  1'b0, 4'h0, 1'b0, 4'h0, 6'b001100, 1'b1}, // R7 masked during drain
    {8'd6,  1'b0, 4'h0, 1'b0, 4'h0, 6'b000101, 1'b1}, // R6 cancel pending stop
    {8'd6,  1'b0, 4'h0, 1'b0, 4'h0, 6'b010000, 1'b1}, // R6 done, no stop
    {8'd2,  1'b0, 4'h0, 1'b1, 4'h1, 6'b010000, 1'b1}, // R2 write in run
    {8'd2,  1'b0, 4'h0, 1'b0, 4'h0, 6'b010000, 1'b0}, // R2 done -> stop
    {8'd8,  1'b1, 4'h1, 1'b0, 4'h0, 6'b000000, 1'b1}, // R8 enable write
    {8'd9,  1'b1, 4'h1, 1'b1, 4'h1, 6'b000000, 1'b1}, // R9 both, disable pends
    {8'd9,  1'b0, 4'h0, 1'b0, 4'h0, 6'b010000, 1'b0}, // R9 stop proves disable won
    {8'd10, 1'b1, 4'h2, 1'b0, 4'h0, 6'b000000, 1'b0}, // R10 set bit1 ignored
    {8'd10, 1'b0, 4'h0, 1'b1, 4'h2, 6'b010000, 1'b0}, // R10 clr bit1 while off
    {8'd8,  1'b1, 4'h1, 1'b0, 4'h0, 6'b000000, 1'b1}  // R8 restart
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    set_we = 0; set_data = '0; clr_we = 0; clr_data = '0;
    wfi_req = 0; insn_done = 0; fiq = 0; irq = 0; fiq_en = 0; irq_en = 0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", {24'd0, status}, 32'h01);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 after reset", {24'd0, status}, 32'h01);

    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VEC[i];
      set_we   = v[16];
      set_data = {4'h0, v[15:12]};
      clr_we   = v[11];
      clr_data = {4'h0, v[10:7]};
      {wfi_req, insn_done, fiq, irq, fiq_en, irq_en} = v[6:1];
      @(negedge clk);
      chk($sformatf("R%0d vec %0d", v[24:17], i), {31'd0, status[0]}, {31'd0, v[0]});
      chk("R4 upper bits", {24'd0, status[DW-1:1], 1'b0}, 32'h0);
      idle_inputs();
    end

    // R11: clock on, count pulses
    begin
      int p0;
      @(negedge clk); p0 = pulses;
      repeat (5) @(negedge clk);
      chk("R11 pulses while on", pulses - p0, 5);
    end
    // R11: stop, then no pulses
    clr_we = 1; clr_data = 8'h01;
    @(negedge clk); idle_inputs(); insn_done = 1;
    @(negedge clk); idle_inputs();
    chk("R2 stopped before count", {31'd0, status[0]}, 0);
    begin
      int p0;
      @(negedge clk); p0 = pulses;
      repeat (5) @(negedge clk);
      chk("R11 no pulses while off", pulses - p0, 0);
    end
    // R7: masked lines held long
    fiq = 1; irq = 1;
    repeat (4) @(negedge clk);
    chk("R7 held masked lines", {31'd0, status[0]}, 0);
    idle_inputs();
    // R8: restart, pulses resume
    set_we = 1; set_data = 8'h01;
    @(negedge clk); idle_inputs();
    chk("R8 restart", {31'd0, status[0]}, 1);
    begin
      int p0;
      @(negedge clk); p0 = pulses;
      repeat (3) @(negedge clk);
      chk("R11 pulses resume", pulses - p0, 3);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule